// File: doc/BRIEF.md
# Counter Overflow Sample PC Capture

This block keeps a sample program counter and a small sample-data field. It updates them whenever a hardware performance counter overflows, so that software can attribute the sampled event to an instruction. A counter whose event supports precise attribution provides the PC of the causal instruction. The block stores that PC aligned down to a granule and puts the low offset into sample-data, so the two fields add back to the causal PC. Any other counter takes the PC of the oldest instruction retiring in the overflow cycle. When nothing retires in that cycle, it takes the PC of the next instruction to retire.

Software reaches the sample PC register through a simple read/write port. The access check depends on the privilege mode and on the counter-delegation enable. When the check fails, the block raises either an illegal-instruction flag or a virtual-instruction flag in the same cycle. While delegation is enabled, only counters marked as delegated can trigger a capture. Every value the register stores, whether captured or written, is first legalized for a 39-bit virtual address space.

Top module: `ovf_sample_pc`

## Requirements
- R1: After reset, `spc_o` and `sdata_o` are zero.
- R2: An eligible overflow in cycle N shows in `spc_o`/`sdata_o` from cycle N+1. With no eligible overflow and no landed write, both outputs hold their value.
- R3: When several eligible counters overflow together, the lowest-numbered one wins. Its index is stored in `sdata_o[GRAN+IDXW-1:GRAN]`.
- R4: For a precise winner, `spc_o` is `cause_pc_i` with its low GRAN bits cleared. Those low bits go to `sdata_o[GRAN-1:0]`, and the sample-data MSB is 1, so `spc_o + sdata_o[GRAN-1:0]` gives the causal PC.
- R5: For a non-precise winner, `spc_o` is the PC of the lowest-indexed valid retire slot. Slot j sits at `ret_pc_i[j*XLEN +: XLEN]`, and slot 0 is the oldest. With no valid slot, `spc_o` is `next_pc_i`. The offset field and the sample-data MSB are 0.
- R6: With `cde_i`=1, only counters whose `deleg_i` bit is set are eligible, and overflows of other counters change nothing. With `cde_i`=0, every counter is eligible.
- R7: The `priv_i` encoding is 3 = machine, 1 = supervisor (virtualized when `virt_i`=1), 0 = user, and 2 = reserved. Machine-mode accesses never fault. Host supervisor accesses are allowed only when `cde_i`=1 and otherwise raise `ill_o`. Virtualized supervisor accesses raise `vfault_o` when `cde_i`=1 and `ill_o` when `cde_i`=0. All other modes raise `ill_o`. Both flags are combinational and assert only while `csr_re_i` or `csr_we_i` is high.
- R8: A write is stored from the next cycle only when it does not fault. A faulting write leaves `spc_o` unchanged.
- R9: An address is valid when bits 63:39 all equal bit 38. A valid address is stored unchanged. An invalid address is stored with bits 63:39 set to the inverse of bit 38 and bits 38:0 kept.
- R10: If a capture and a permitted write happen in the same cycle, the capture is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ovf_i | input | NCNT | Per-counter overflow pulse |
| precise_i | input | NCNT | Per-counter precise-attribution flag |
| deleg_i | input | NCNT | Per-counter delegation mask |
| cause_pc_i | input | XLEN | Causal instruction PC for precise events |
| ret_pc_i | input | NRET*XLEN | Retire slot PCs, slot 0 oldest |
| ret_vld_i | input | NRET | Retire slot valid flags |
| next_pc_i | input | XLEN | PC of next instruction to retire |
| cde_i | input | 1 | Counter delegation enable |
| priv_i | input | 2 | Privilege mode |
| virt_i | input | 1 | Virtualized mode |
| csr_re_i | input | 1 | Register read strobe |
| csr_we_i | input | 1 | Register write strobe |
| csr_wdata_i | input | XLEN | Register write data |
| spc_o | output | XLEN | Sample PC register |
| sdata_o | output | GRAN+IDXW+1 | Sample data {precise, index, offset} |
| ill_o | output | 1 | Illegal-instruction fault |
| vfault_o | output | 1 | Virtual-instruction fault |

## Verification
The bench builds the block with eight counters, three retire slots, a 64-bit register and a 16-byte granule. With eight counters, random overflow vectors often have several bits set under a random delegation mask, which exercises the lowest-index selection in both delegation states. Three retire slots allow every pattern of valid flags, including gaps ahead of the oldest valid slot and the empty case that falls back to the next PC. Random PCs are sometimes non-canonical so that legalization is reached on both the capture path and the write path.

// File: rtl/ovf_sample_pc.sv
module ovf_sample_pc #(
  parameter int NCNT = 8,
  parameter int NRET = 2,
  parameter int XLEN = 64,
  parameter int VA   = 39,
  parameter int GRAN = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NCNT-1:0]              ovf_i,
  input  logic [NCNT-1:0]              precise_i,
  input  logic [NCNT-1:0]              deleg_i,
  input  logic [XLEN-1:0]              cause_pc_i,
  input  logic [NRET*XLEN-1:0]         ret_pc_i,
  input  logic [NRET-1:0]              ret_vld_i,
  input  logic [XLEN-1:0]              next_pc_i,
  input  logic                         cde_i,
  input  logic [1:0]                   priv_i,
  input  logic                         virt_i,
  input  logic                         csr_re_i,
  input  logic                         csr_we_i,
  input  logic [XLEN-1:0]              csr_wdata_i,
  output logic [XLEN-1:0]              spc_o,
  output logic [GRAN+$clog2(NCNT):0]   sdata_o,
  output logic                         ill_o,
  output logic                         vfault_o
);
  localparam int IDXW = $clog2(NCNT);
  localparam int SDW  = GRAN + IDXW + 1;
  localparam int UPW  = XLEN - VA;

  function automatic logic [XLEN-1:0] legalize(input logic [XLEN-1:0] a);
    logic s;
    s = a[VA-1];
    if (a[XLEN-1:VA] == {UPW{s}}) return a;
    return {{UPW{~s}}, a[VA-1:0]};
  endfunction

  logic [NCNT-1:0] elig;
  logic            hit;
  logic [IDXW-1:0] idx;
  logic [XLEN-1:0] ret_sel;
  logic            prec;
  logic [XLEN-1:0] raw_pc;
  logic [GRAN-1:0] off;

  assign elig = ovf_i & (cde_i ? deleg_i : {NCNT{1'b1}});

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NCNT-1; i >= 0; i--) begin
      if (elig[i]) begin
        hit = 1'b1;
        idx = IDXW'(i);
      end
    end
  end

  always_comb begin
    ret_sel = next_pc_i;
    for (int j = NRET-1; j >= 0; j--) begin
      if (ret_vld_i[j]) ret_sel = ret_pc_i[j*XLEN +: XLEN];
    end
  end

  assign prec   = precise_i[idx];
  assign raw_pc = prec ? {cause_pc_i[XLEN-1:GRAN], {GRAN{1'b0}}} : ret_sel;
  assign off    = prec ? cause_pc_i[GRAN-1:0] : '0;

  logic acc, m_mode, hs_mode, vs_mode, ok, wr;
  assign acc      = csr_re_i | csr_we_i;
  assign m_mode   = (priv_i == 2'd3);
  assign hs_mode  = (priv_i == 2'd1) & ~virt_i;
  assign vs_mode  = (priv_i == 2'd1) & virt_i;
  assign ok       = m_mode | (hs_mode & cde_i);
  assign vfault_o = acc & vs_mode & cde_i;
  assign ill_o    = acc & ~ok & ~(vs_mode & cde_i);
  assign wr       = csr_we_i & ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spc_o   <= '0;
      sdata_o <= '0;
    end else if (hit) begin
      spc_o   <= legalize(raw_pc);
      sdata_o <= SDW'({prec, idx, off});
    end else if (wr) begin
      spc_o   <= legalize(csr_wdata_i);
    end
  end
endmodule

module ovf_sample_pc_chk #(
  parameter int NCNT = 8,
  parameter int NRET = 2,
  parameter int XLEN = 64,
  parameter int VA   = 39,
  parameter int GRAN = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NCNT-1:0]              ovf_i,
  input logic [NCNT-1:0]              precise_i,
  input logic [NCNT-1:0]              deleg_i,
  input logic [XLEN-1:0]              cause_pc_i,
  input logic [NRET*XLEN-1:0]         ret_pc_i,
  input logic [NRET-1:0]              ret_vld_i,
  input logic [XLEN-1:0]              next_pc_i,
  input logic                         cde_i,
  input logic [1:0]                   priv_i,
  input logic                         virt_i,
  input logic                         csr_re_i,
  input logic                         csr_we_i,
  input logic [XLEN-1:0]              csr_wdata_i,
  input logic [XLEN-1:0]              spc_o,
  input logic [GRAN+$clog2(NCNT):0]   sdata_o,
  input logic                         ill_o,
  input logic                         vfault_o
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_i == '0 && !csr_we_i) |=> ($stable(spc_o) && $stable(sdata_o)));

  p_undelegated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cde_i && (ovf_i & deleg_i) == '0 && !csr_we_i) |=> ($stable(spc_o) && $stable(sdata_o)));

  p_one_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ill_o && vfault_o));

  p_machine_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i == 2'd3) |-> (!ill_o && !vfault_o));

  p_no_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!csr_re_i && !csr_we_i) |-> (!ill_o && !vfault_o));

  p_vs_virtual_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((csr_re_i || csr_we_i) && priv_i == 2'd1 && virt_i && cde_i) |-> vfault_o);

  p_bad_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_i == '0 && csr_we_i && ill_o) |=> $stable(spc_o));

  p_upper_uniform_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((&spc_o[XLEN-1:VA]) || !(|spc_o[XLEN-1:VA])));
endmodule

bind ovf_sample_pc ovf_sample_pc_chk #(
  .NCNT(NCNT), .NRET(NRET), .XLEN(XLEN), .VA(VA), .GRAN(GRAN)
) u_chk (.*);

// File: tb/sim_ovf_sample_pc.sv
module sim_ovf_sample_pc;
  localparam int NCNT = 8;
  localparam int NRET = 3;
  localparam int XLEN = 64;
  localparam int VA   = 39;
  localparam int GRAN = 4;
  localparam int IDXW = $clog2(NCNT);
  localparam int SDW  = GRAN + IDXW + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCNT-1:0] ovf, prec, deleg;
  logic [XLEN-1:0] cause_pc, next_pc, wdata;
  logic [NRET*XLEN-1:0] ret_pc;
  logic [NRET-1:0] ret_vld;
  logic cde, virt, re, we;
  logic [1:0] priv;
  logic [XLEN-1:0] spc;
  logic [SDW-1:0] sdata;
  logic ill, vf;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [XLEN-1:0] m_spc;
  logic [SDW-1:0]  m_sd;

  always #4 clk = ~clk;

  ovf_sample_pc #(.NCNT(NCNT), .NRET(NRET), .XLEN(XLEN), .VA(VA), .GRAN(GRAN)) u0 (
    .clk(clk), .rst_n(rst_n), .ovf_i(ovf), .precise_i(prec), .deleg_i(deleg),
    .cause_pc_i(cause_pc), .ret_pc_i(ret_pc), .ret_vld_i(ret_vld), .next_pc_i(next_pc),
    .cde_i(cde), .priv_i(priv), .virt_i(virt), .csr_re_i(re), .csr_we_i(we),
    .csr_wdata_i(wdata), .spc_o(spc), .sdata_o(sdata), .ill_o(ill), .vfault_o(vf));

  function automatic logic [XLEN-1:0] canon(input logic [XLEN-1:0] a);
    if (a[XLEN-1:VA] == {(XLEN-VA){a[VA-1]}}) return a;
    return {{(XLEN-VA){~a[VA-1]}}, a[VA-1:0]};
  endfunction

  function automatic logic exp_ill();
    logic acc;
    acc = re | we;
    if (!acc || priv == 2'd3) return 1'b0;
    if (priv == 2'd1 && !virt) return !cde;
    if (priv == 2'd1 && virt) return !cde;
    return 1'b1;
  endfunction

  function automatic logic exp_vf();
    return (re | we) && priv == 2'd1 && virt && cde;
  endfunction

  task automatic model_step();
    logic [NCNT-1:0] el;
    int w;
    logic [XLEN-1:0] p;
    el = ovf & (cde ? deleg : '1);
    w = -1;
    for (int i = 0; i < NCNT; i++) if (el[i] && w < 0) w = i;
    if (w >= 0) begin
      if (prec[w]) begin
        m_spc = canon({cause_pc[XLEN-1:GRAN], {GRAN{1'b0}}});
        m_sd  = {1'b1, IDXW'(w), cause_pc[GRAN-1:0]};
      end else begin
        p = next_pc;
        for (int j = 0; j < NRET; j++) if (ret_vld[j]) begin p = ret_pc[j*XLEN +: XLEN]; break; end
        m_spc = canon(p);
        m_sd  = {1'b0, IDXW'(w), {GRAN{1'b0}}};
      end
    end else if (we && !exp_ill() && !exp_vf()) begin
      m_spc = canon(wdata);
    end
  endtask

  task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ovf = '0; prec = '0; deleg = '0; cause_pc = '0; next_pc = '0; wdata = '0;
    ret_pc = '0; ret_vld = '0; cde = 0; virt = 0; re = 0; we = 0; priv = 2'd3;
  endtask

  // inputs already driven after a negedge; checks comb, clocks, checks registers
  task automatic tick(input string tag);
    #1;
    chk({tag, " ill"}, XLEN'(ill), XLEN'(exp_ill()));
    chk({tag, " vfault"}, XLEN'(vf), XLEN'(exp_vf()));
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk({tag, " spc"}, spc, m_spc);
    chk({tag, " sdata"}, XLEN'(sdata), XLEN'(m_sd));
    idle();
  endtask

  function automatic logic [XLEN-1:0] rnd_pc();
    logic [XLEN-1:0] v;
    v = {$urandom, $urandom};
    if ($urandom % 6 != 0) v = {{(XLEN-VA){v[VA-1]}}, v[VA-1:0]};
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250108));
    idle();
    m_spc = '0; m_sd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset spc", spc, '0);
    chk("R1 reset sdata", XLEN'(sdata), '0);
    rst_n = 1'b1;

    // R3: lowest index wins, cde off (R6)
    ovf = 8'b0010_0100; next_pc = 64'h1000; tick("R3 R6 lowest");
    chk("R3 index", XLEN'(sdata[GRAN+IDXW-1:GRAN]), 64'd2);
    // R6: delegation filters
    cde = 1; deleg = 8'b0010_0000; ovf = 8'b0010_0100; next_pc = 64'h2000; tick("R6 deleg");
    chk("R6 index", XLEN'(sdata[GRAN+IDXW-1:GRAN]), 64'd5);
    cde = 1; deleg = 8'b0010_0000; ovf = 8'b0000_0100; next_pc = 64'h3000; tick("R6 undeleg");
    chk("R6 unchanged", spc, 64'h2000);
    // R4 precise
    ovf = 8'b0000_1000; prec = 8'b0000_1000; cause_pc = 64'h0000_0012_3456_789B; tick("R4 precise");
    chk("R4 aligned", spc, 64'h0000_0012_3456_7890);
    chk("R4 recover", spc + XLEN'(sdata[GRAN-1:0]), 64'h0000_0012_3456_789B);
    chk("R4 flag", XLEN'(sdata[SDW-1]), 64'd1);
    // R5 retire selection
    ovf = 8'b1; ret_vld = 3'b110; ret_pc = {64'hC00, 64'hB00, 64'hA00}; next_pc = 64'hD00; tick("R5 oldest");
    chk("R5 slot1", spc, 64'hB00);
    ovf = 8'b1; ret_vld = 3'b000; ret_pc = {64'hC00, 64'hB00, 64'hA00}; next_pc = 64'hD00; tick("R5 none");
    chk("R5 nextpc", spc, 64'hD00);
    // R9 legalization
    we = 1; wdata = 64'h0000_0080_0000_0000; tick("R9 invalid");
    chk("R9 flipped", spc, 64'hFFFF_FF80_0000_0000);
    we = 1; wdata = 64'hFFFF_FFC0_0000_1000; tick("R9 valid");
    chk("R9 kept", spc, 64'hFFFF_FFC0_0000_1000);
    // R10 capture beats write
    we = 1; wdata = 64'h5555; ovf = 8'b1; next_pc = 64'h7770; tick("R10 prio");
    chk("R10 capture", spc, 64'h7770);
    // R7 / R8 faults
    priv = 2'd1; re = 1; cde = 0; tick("R7 S nodeleg");
    priv = 2'd1; we = 1; cde = 0; wdata = 64'h4440; tick("R8 S write blocked");
    chk("R8 unchanged", spc, 64'h7770);
    priv = 2'd1; we = 1; cde = 1; wdata = 64'h4440; tick("R8 S write ok");
    chk("R8 landed", spc, 64'h4440);
    priv = 2'd1; virt = 1; re = 1; cde = 1; tick("R7 VS deleg");
    priv = 2'd1; virt = 1; re = 1; cde = 0; tick("R7 VS nodeleg");
    priv = 2'd0; we = 1; cde = 1; wdata = 64'h9990; tick("R7 U");
    chk("R8 U blocked", spc, 64'h4440);
    // R2 hold
    re = 1; tick("R2 hold");

    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 3 == 0) ovf = NCNT'($urandom);
      prec = NCNT'($urandom); deleg = NCNT'($urandom); cde = 1'($urandom);
      cause_pc = rnd_pc(); next_pc = rnd_pc();
      for (int j = 0; j < NRET; j++) ret_pc[j*XLEN +: XLEN] = rnd_pc();
      ret_vld = NRET'($urandom);
      priv = 2'($urandom); virt = 1'($urandom);
      re = ($urandom % 4 == 0); we = ($urandom % 3 == 0); wdata = rnd_pc();
      tick("R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule